// File: doc/BRIEF.md
# Automatic Coarse-Approach Supervisor

This block sits between a host control word and the analog front end of a tunneling probe instrument. It turns a 10-bit control word into the discrete controls the front end needs: the feedback-loop enable and bypass, the integrator hold, the scan-mode select, the digitizer source and a one-hot programmable-gain value. It also produces the coarse walker's step pulse and step direction.

Its main job is automatic approach. When the host turns the feedback loop on, the supervisor leaves `IDLE` and enters `SEEK`. In `SEEK` it sends forward walker steps, and it starts each step only after the walker reports that it is free. It checks every digitized tunneling-voltage sample against a programmable magnitude threshold. One sample above the threshold moves it to `ARMED`, where it stops stepping. A second consecutive sample above the threshold moves it to `LOCKED`, and the feedback loop then keeps control of the tip. A sample below the threshold while in `ARMED` returns it to `SEEK`.

The state machine has four states and these transitions:
- `IDLE` to `SEEK`: the loop-on bit rises, with no backward step requested in the same write.
- `SEEK` to `ARMED`: one sample is above the threshold.
- `ARMED` to `LOCKED`: the next sample is also above the threshold.
- `ARMED` to `SEEK`: the next sample is at or below the threshold.
- `SEEK` or `ARMED` to `IDLE`: the host requests a backward step (abort).
- Any state to `IDLE`: a write clears the loop-on bit.

Top module: `approach_supervisor`

## Requirements
- R1: After a write, the outputs follow the control word. Bit 3 drives mode_height, bit 5 drives int_hold, bit 6 drives loop_en, bit 7 drives loop_bypass, and bit 9 drives walk_dir (1 = forward) outside approach. Bit 8 is a step-request strobe and is not stored. Reset clears the word.
- R2: pga_gain equals 2 raised to the code in bits 2:0, so it ranges from 1 to 128 and is always one-hot.
- R3: adc_sel is 1 (integrator output) only when bit 4 is set, the loop is on and approach is not active. Otherwise it is 0 (tunneling voltage).
- R4: A write that sets the loop bit while it was clear, with the machine in IDLE, starts approach. Rewriting the loop bit when it is already on does not restart approach. During approach, walk_dir is 1.
- R5: A walker step pulse is one cycle wide. It never starts in the cycle after walker_busy was high. Two step pulses are never back to back.
- R6: A sample counts as a hit when its two's-complement magnitude is strictly greater than the threshold, including the most negative code. The machine locks only on two consecutive valid hits. A non-hit sample in between starts the count again.
- R7: Once locked, feedback_active is high, approach_active is low, the loop stays enabled and no further automatic steps are issued.
- R8: A forward step request written during approach is discarded and never produces a pulse later.
- R9: A backward step request written during approach cancels approach and produces exactly one backward step.
- R10: A write that clears the loop bit returns the machine to IDLE from any state.
- R11: Outside approach, a step request in either direction is held until the walker is free. It then produces exactly one step in the written direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 10 | Control word |
| thresh | input | ADC_W | Unsigned magnitude threshold for tunneling detection |
| adc_valid | input | 1 | Sample strobe |
| adc_data | input | ADC_W | Signed tunneling-voltage sample |
| walker_busy | input | 1 | Walker is still executing a step |
| walk_pulse | output | 1 | One-cycle walker step request |
| walk_dir | output | 1 | Step direction, 1 = forward |
| loop_en | output | 1 | Feedback loop enable |
| loop_bypass | output | 1 | Feedback loop bypass |
| int_hold | output | 1 | Integrator hold |
| mode_height | output | 1 | 1 = constant-height mode, 0 = constant-current mode |
| adc_sel | output | 1 | Digitizer source, 1 = integrator output |
| pga_gain | output | 8 | One-hot gain value |
| approach_active | output | 1 | Machine is in SEEK or ARMED |
| feedback_active | output | 1 | Machine is in LOCKED |

## Verification
The hardest case to reach is a forward step request written during approach. It must leave no trace, but while steps are flowing, a stray pulse cannot be told apart from an automatic one. The bench therefore holds walker_busy high before starting approach, so that no automatic step can occur. It then writes the forward request and drives two hits to reach LOCKED, where automatic stepping has ended. Finally it releases the walker, and any latched request would now appear as a pulse. Threshold equality, alternating hit and non-hit samples, and the most negative sample code are driven directly.

// File: rtl/apx_pkg.sv
package apx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEEK   = 2'd1,
        ST_ARMED  = 2'd2,
        ST_LOCKED = 2'd3
    } apx_state_t;

endpackage

// File: rtl/apx_ctrl_word.sv
module apx_ctrl_word #(
    parameter int GAIN_BITS = 3,
    localparam int CTRL_W   = GAIN_BITS + 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CTRL_W-1:0]    wdata,
    output logic [GAIN_BITS-1:0] gain_code,
    output logic                 mode_q,
    output logic                 src_q,
    output logic                 hold_q,
    output logic                 loop_q,
    output logic                 byp_q,
    output logic                 dir_q,
    output logic                 loop_rise,
    output logic                 loop_off_wr,
    output logic                 step_req,
    output logic                 step_dir
);
    localparam int B_MODE  = GAIN_BITS;
    localparam int B_SRC   = GAIN_BITS + 1;
    localparam int B_HOLD  = GAIN_BITS + 2;
    localparam int B_LOOP  = GAIN_BITS + 3;
    localparam int B_BYP   = GAIN_BITS + 4;
    localparam int B_STEP  = GAIN_BITS + 5;
    localparam int B_DIR   = GAIN_BITS + 6;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= '0;
            mode_q    <= 1'b0;
            src_q     <= 1'b0;
            hold_q    <= 1'b0;
            loop_q    <= 1'b0;
            byp_q     <= 1'b0;
            dir_q     <= 1'b0;
        end else if (wr) begin
            gain_code <= wdata[GAIN_BITS-1:0];
            mode_q    <= wdata[B_MODE];
            src_q     <= wdata[B_SRC];
            hold_q    <= wdata[B_HOLD];
            loop_q    <= wdata[B_LOOP];
            byp_q     <= wdata[B_BYP];
            dir_q     <= wdata[B_DIR];
        end
    end

    always_comb begin
        loop_rise   = wr &&  wdata[B_LOOP] && !loop_q;
        loop_off_wr = wr && !wdata[B_LOOP];
        step_req    = wr &&  wdata[B_STEP];
        step_dir    = wdata[B_DIR];
    end

endmodule

// File: rtl/apx_level_detect.sv
module apx_level_detect #(
    parameter int ADC_W = 16
) (
    input  logic              valid,
    input  logic [ADC_W-1:0]  sample,
    input  logic [ADC_W-1:0]  limit,
    output logic              hit
);
    localparam int MAG_W = ADC_W + 1;

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;

    always_comb begin
        ext = {sample[ADC_W-1], sample};
        mag = sample[ADC_W-1] ? (~ext + MAG_W'(1)) : ext;
        hit = valid && (mag > {1'b0, limit});
    end

endmodule

// File: rtl/apx_seq_fsm.sv
module apx_seq_fsm
    import apx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_rise,
    input  logic       loop_off_wr,
    input  logic       step_req,
    input  logic       step_dir,
    input  logic       sample_valid,
    input  logic       hit,
    input  logic       walker_busy,
    output apx_state_t state_q,
    output logic       seeking,
    output logic       pulse_q
);
    apx_state_t state_d;
    logic       abort;
    logic       accept;
    logic       pend_q;

    always_comb begin
        seeking = (state_q == ST_SEEK) || (state_q == ST_ARMED);
        abort   = step_req && !step_dir;
        accept  = step_req && !(seeking && step_dir);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (loop_rise && !abort) state_d = ST_SEEK;
            end
            ST_SEEK: begin
                if (abort)    state_d = ST_IDLE;
                else if (hit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (abort)             state_d = ST_IDLE;
                else if (sample_valid) state_d = hit ? ST_LOCKED : ST_SEEK;
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_IDLE;
        endcase
        if (loop_off_wr) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!walker_busy && !pulse_q) begin
                if (pend_q) begin
                    pulse_q <= 1'b1;
                    pend_q  <= 1'b0;
                end else if (state_d == ST_SEEK) begin
                    pulse_q <= 1'b1;
                end
            end
            if (accept) pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/approach_supervisor.sv
module approach_supervisor
    import apx_pkg::*;
#(
    parameter int ADC_W     = 16,
    parameter int GAIN_BITS = 3,
    localparam int CTRL_W   = GAIN_BITS + 7,
    localparam int PGA_W    = 1 << GAIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic [ADC_W-1:0]  thresh,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              walker_busy,
    output logic              walk_pulse,
    output logic              walk_dir,
    output logic              loop_en,
    output logic              loop_bypass,
    output logic              int_hold,
    output logic              mode_height,
    output logic              adc_sel,
    output logic [PGA_W-1:0]  pga_gain,
    output logic              approach_active,
    output logic              feedback_active
);
    logic [GAIN_BITS-1:0] gain_code;
    logic src_q, dir_q, loop_rise, loop_off_wr, step_req, step_dir;
    logic hit, seeking;
    apx_state_t state_q;

    apx_ctrl_word #(.GAIN_BITS(GAIN_BITS)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctrl_wr),
        .wdata      (ctrl_data),
        .gain_code  (gain_code),
        .mode_q     (mode_height),
        .src_q      (src_q),
        .hold_q     (int_hold),
        .loop_q     (loop_en),
        .byp_q      (loop_bypass),
        .dir_q      (dir_q),
        .loop_rise  (loop_rise),
        .loop_off_wr(loop_off_wr),
        .step_req   (step_req),
        .step_dir   (step_dir)
    );

    apx_level_detect #(.ADC_W(ADC_W)) u_level (
        .valid (adc_valid),
        .sample(adc_data),
        .limit (thresh),
        .hit   (hit)
    );

    apx_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_rise   (loop_rise),
        .loop_off_wr (loop_off_wr),
        .step_req    (step_req),
        .step_dir    (step_dir),
        .sample_valid(adc_valid),
        .hit         (hit),
        .walker_busy (walker_busy),
        .state_q     (state_q),
        .seeking     (seeking),
        .pulse_q     (walk_pulse)
    );

    always_comb begin
        walk_dir        = seeking ? 1'b1 : dir_q;
        adc_sel         = src_q && loop_en && !seeking;
        pga_gain        = PGA_W'(1) << gain_code;
        approach_active = seeking;
        feedback_active = (state_q == ST_LOCKED);
    end

endmodule

// File: rtl/approach_supervisor_chk.sv
module approach_supervisor_chk #(
    parameter int ADC_W     = 16,
    parameter int GAIN_BITS = 3,
    localparam int CTRL_W   = GAIN_BITS + 7,
    localparam int PGA_W    = 1 << GAIN_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [CTRL_W-1:0] ctrl_data,
    input logic [ADC_W-1:0]  thresh,
    input logic              adc_valid,
    input logic [ADC_W-1:0]  adc_data,
    input logic              walker_busy,
    input logic              walk_pulse,
    input logic              walk_dir,
    input logic              loop_en,
    input logic              loop_bypass,
    input logic              int_hold,
    input logic              mode_height,
    input logic              adc_sel,
    input logic [PGA_W-1:0]  pga_gain,
    input logic              approach_active,
    input logic              feedback_active
);
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        walk_pulse |=> !walk_pulse);

    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        walker_busy |=> !walk_pulse);

    a_r2_gain_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pga_gain) == 1);

    a_r3_tunnel_during_seek: assert property (@(posedge clk) disable iff (!rst_n)
        approach_active |-> !adc_sel);

    a_r3_integ_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sel |-> loop_en);

    a_r7_locked_loop_on: assert property (@(posedge clk) disable iff (!rst_n)
        feedback_active |-> (loop_en && !approach_active));

    a_r6_lock_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feedback_active) |-> $past(adc_valid));

    a_r4_seek_steps_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_pulse && approach_active) |-> walk_dir);

    a_r10_loop_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_data[GAIN_BITS+3]) |=> (!approach_active && !feedback_active));

endmodule

bind approach_supervisor approach_supervisor_chk #(
    .ADC_W    (ADC_W),
    .GAIN_BITS(GAIN_BITS)
) u_chk (.*);

// File: tb/approach_supervisor_test.sv
module approach_supervisor_test;

    localparam int ADC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [9:0]        ctrl_data = '0;
    logic [ADC_W-1:0]  thresh = '0;
    logic              adc_valid = 1'b0;
    logic [ADC_W-1:0]  adc_data = '0;
    logic              walker_busy;
    logic              walk_pulse, walk_dir, loop_en, loop_bypass, int_hold;
    logic              mode_height, adc_sel, approach_active, feedback_active;
    logic [7:0]        pga_gain;

    logic busy_force = 1'b0;
    int   busy_cnt = 0;
    int   pulse_cnt = 0;
    int   bwd_cnt = 0;
    int   total = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign walker_busy = busy_force || (busy_cnt != 0);

    approach_supervisor uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .thresh(thresh), .adc_valid(adc_valid), .adc_data(adc_data),
        .walker_busy(walker_busy), .walk_pulse(walk_pulse), .walk_dir(walk_dir),
        .loop_en(loop_en), .loop_bypass(loop_bypass), .int_hold(int_hold),
        .mode_height(mode_height), .adc_sel(adc_sel), .pga_gain(pga_gain),
        .approach_active(approach_active), .feedback_active(feedback_active)
    );

    // walker model: busy for three cycles after each step
    always @(negedge clk) begin
        if (walk_pulse) begin
            pulse_cnt = pulse_cnt + 1;
            if (!walk_dir) bwd_cnt = bwd_cnt + 1;
            busy_cnt = 3;
        end else if (busy_cnt != 0) begin
            busy_cnt = busy_cnt - 1;
        end
    end

    function automatic logic [9:0] mk(input bit dir, input bit step, input bit byp,
                                      input bit loop, input bit hold, input bit src,
                                      input bit mode, input int gain);
        return {dir, step, byp, loop, hold, src, mode, 3'(gain)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [9:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_data = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_data = '0;
        #1;
    endtask

    task automatic sample(input int v);
        @(negedge clk);
        adc_valid = 1'b1;
        adc_data = ADC_W'(v);
        @(negedge clk);
        adc_valid = 1'b0;
        adc_data = '0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int c0;
        int b0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // reset state (R1, R2)
        check({walk_pulse, walk_dir, loop_en, loop_bypass, int_hold, mode_height,
               adc_sel, approach_active, feedback_active} == 9'b0, "R1 reset",
              int'({walk_pulse, walk_dir, loop_en, approach_active}), 0);
        check(pga_gain == 8'd1, "R2 reset gain", int'(pga_gain), 1);

        // R1/R2/R3 sweep over all fields with loop off
        for (int i = 0; i < 256; i++) begin
            int exp_v;
            int act_v;
            wr(mk(i[7], 1'b0, i[6], 1'b0, i[5], i[4], i[3], i & 7));
            exp_v = ((1 << (i & 7)) << 6) | (i[3] << 5) | (i[5] << 4) | (i[6] << 3)
                    | (i[7] << 2);
            act_v = int'({pga_gain, mode_height, int_hold, loop_bypass, walk_dir,
                          loop_en, adc_sel});
            check(act_v == exp_v, "R1 R2 R3 field sweep", act_v, exp_v);
        end

        // R4 start approach, forward stepping
        wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        thresh = 16'd1000;
        c0 = pulse_cnt;
        b0 = bwd_cnt;
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2));
        check(approach_active && loop_en, "R4 approach start", int'(approach_active), 1);
        check(adc_sel == 1'b0, "R3 tunnel source in approach", int'(adc_sel), 0);
        settle(30);
        check(pulse_cnt - c0 >= 6, "R4 R5 steps issued", pulse_cnt - c0, 6);
        check(bwd_cnt == b0, "R4 steps forward", bwd_cnt - b0, 0);

        // R6 threshold boundary and consecutive rule
        sample(1000);
        sample(-1000);
        check(approach_active && !feedback_active, "R6 equal not hit",
              int'(feedback_active), 0);
        sample(1001);
        sample(5);
        sample(1001);
        check(approach_active && !feedback_active, "R6 broken pair",
              int'(feedback_active), 0);
        sample(-1001);
        check(feedback_active && !approach_active, "R6 lock on pair",
              int'(feedback_active), 1);
        settle(6);
        c0 = pulse_cnt;
        settle(20);
        check(pulse_cnt == c0, "R7 no steps when locked", pulse_cnt - c0, 0);
        check(loop_en && adc_sel, "R7 R3 loop kept, integrator source",
              int'({loop_en, adc_sel}), 3);

        // R10 loop off from locked
        wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2));
        check(!feedback_active && !loop_en && !adc_sel, "R10 loop off",
              int'({feedback_active, loop_en, adc_sel}), 0);

        // R8 forward request during approach is discarded
        busy_force = 1'b1;
        settle(6);
        c0 = pulse_cnt;
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        wr(mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        check(approach_active == 1'b1, "R8 approach continues", int'(approach_active), 1);
        sample(2000);
        sample(2000);
        check(feedback_active == 1'b1, "R8 locked", int'(feedback_active), 1);
        busy_force = 1'b0;
        settle(15);
        check(pulse_cnt == c0, "R8 forward request discarded", pulse_cnt - c0, 0);

        // R10 loop off from approach
        wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        settle(5);
        wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        check(!approach_active, "R10 loop off in approach", int'(approach_active), 0);

        // R9 backward request aborts approach
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0));
        settle(12);
        c0 = pulse_cnt;
        b0 = bwd_cnt;
        wr(mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0));
        check(!approach_active && !walk_dir && adc_sel, "R9 abort to idle",
              int'({approach_active, walk_dir, adc_sel}), 1);
        settle(10);
        check(pulse_cnt - c0 == 1 && bwd_cnt - b0 == 1, "R9 one backward step",
              pulse_cnt - c0, 1);

        // R4 rewriting loop-on does not restart approach
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        check(!approach_active, "R4 no restart", int'(approach_active), 0);

        // R11 step request outside approach, held while busy
        wr(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        settle(6);
        busy_force = 1'b1;
        c0 = pulse_cnt;
        b0 = bwd_cnt;
        wr(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        settle(10);
        check(pulse_cnt == c0, "R5 R11 held while busy", pulse_cnt - c0, 0);
        busy_force = 1'b0;
        settle(6);
        check(pulse_cnt - c0 == 1 && bwd_cnt == b0, "R11 one forward step",
              pulse_cnt - c0, 1);

        // R6 most negative code against largest threshold
        thresh = 16'd32767;
        wr(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        sample(32767);
        sample(-32767);
        check(approach_active && !feedback_active, "R6 full-scale not hit",
              int'(feedback_active), 0);
        sample(-32768);
        sample(-32768);
        check(feedback_active == 1'b1, "R6 most negative hit", int'(feedback_active), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule